// File: doc/BRIEF.md
# Dual-Lane Flash Completion Poller

This host-side block waits for a program or erase operation to finish in a 16-bit flash array made of two byte-wide devices. After a start pulse it reads one verify address again and again. Each byte lane is judged on its own: first the low byte, then the high byte. It uses one of two completion tests, chosen at start. In the data-compare test, the lane's status bit is matched against the expected data bit. In the toggle test, the lane's toggle bit is watched until it stops changing between reads.

A lane that is not yet complete can show its exceeded-limit flag, or its wait timer can run out. Either one earns the lane exactly one extra read. The lane fails only if that read still shows it incomplete. When both lanes are settled, the block pulses `done` and presents a 2-bit error code. The code adds 1 for a failed low lane and 2 for a failed high lane. Issuing the program or erase command sequence is left to other logic.

Top module: `flash_done_poller`

## Requirements
- R1: After reset `busy`, `done`, `rd_req` and `err_code` are all 0.
- R2: A `start` pulse while idle latches `toggle_mode`, `verify_addr` and `expect_data`, raises `busy` on the next edge, and holds `rd_req` high with `rd_addr` equal to the latched address until the poll ends. A `start` while busy has no effect on the outputs or the result.
- R3: In data-compare mode (`toggle_mode`=0) a read completes the low lane when `rd_data[7]` equals `expect_data[7]`, and the high lane when `rd_data[15]` equals `expect_data[15]`. For an erase the expected bit is 1, and a status bit of 0 means still busy.
- R4: In toggle mode (`toggle_mode`=1) the first read of a lane only records its toggle bit (`rd_data[6]` low lane, `rd_data[14]` high lane). A later read completes the lane when that bit equals its value in the lane's previous read.
- R5: A judged read that does not complete the lane, while its exceeded-limit bit (`rd_data[5]` low, `rd_data[13]` high) is 1 or its timer has expired, causes exactly one more read. If that read completes the lane, the lane passes. Otherwise the lane fails.
- R6: Each lane's timer restarts at 0 when the lane begins, counts one per clock, and counts as expired once it reaches `TIMEOUT` cycles.
- R7: The low lane is polled to a verdict before any read is judged for the high lane. The high lane starts with no toggle reference and no pending re-read.
- R8: On the edge that settles the high lane, `busy` falls and `done` pulses for one cycle. `err_code` becomes (low failed ? 1 : 0) + (high failed ? 2 : 0) and holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a poll when idle |
| toggle_mode | input | 1 | 0 = data-compare test, 1 = toggle test |
| verify_addr | input | AW | Address to read during the poll |
| expect_data | input | 16 | Data last written (all ones for erase) |
| rd_req | output | 1 | Read wanted; a read completes in each cycle with `rd_ack` |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read response valid this cycle |
| rd_data | input | 16 | Read response data |
| busy | output | 1 | Poll in progress |
| done | output | 1 | One-cycle pulse at poll end |
| err_code | output | 2 | Bit 0 low lane failed, bit 1 high lane failed |

## Verification
The assertions take for granted that `rd_ack` only matters while `rd_req` is high, and that each acknowledged cycle carries a whole 16-bit word. The bench drives acknowledges only in cycles where `rd_req` is high. It spaces them irregularly, with two acks out of every three cycles, and draws the data from a scripted word list per scenario. Once the list runs out, it returns zero. The `start` pin is pulsed once in the middle of a poll to show it has no effect, and at no other time outside idle.

// File: rtl/flash_done_poller.sv
module flash_done_poller #(
  parameter int AW      = 21,
  parameter int TIMEOUT = 1000,
  localparam int TW     = $clog2(TIMEOUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          toggle_mode,
  input  logic [AW-1:0] verify_addr,
  input  logic [15:0]   expect_data,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [15:0]   rd_data,
  output logic          busy,
  output logic          done,
  output logic [1:0]    err_code
);

  logic          busy_q, hi_q, have_ref, ref_bit, recheck, fail_lo, mode_q, done_q;
  logic [1:0]    err_q;
  logic [15:0]   exp_q;
  logic [AW-1:0] addr_q;
  logic [TW-1:0] tmr;

  wire hit      = busy_q && rd_ack;
  wire st_bit   = hi_q ? rd_data[15] : rd_data[7];
  wire tg_bit   = hi_q ? rd_data[14] : rd_data[6];
  wire lim_bit  = hi_q ? rd_data[13] : rd_data[5];
  wire exp_bit  = hi_q ? exp_q[15]   : exp_q[7];
  wire expired  = (tmr == TW'(TIMEOUT));
  wire judged   = !mode_q || have_ref;
  wire complete = mode_q ? (have_ref && (tg_bit == ref_bit)) : (st_bit == exp_bit);
  wire settle   = judged && (complete || recheck);
  wire lane_bad = !complete;
  wire escalate = judged && !complete && !recheck && (lim_bit || expired);

  assign busy     = busy_q;
  assign rd_req   = busy_q;
  assign rd_addr  = addr_q;
  assign done     = done_q;
  assign err_code = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; hi_q <= 1'b0; have_ref <= 1'b0; ref_bit <= 1'b0;
      recheck <= 1'b0; fail_lo <= 1'b0; mode_q <= 1'b0; done_q <= 1'b0;
      err_q <= 2'd0; exp_q <= '0; addr_q <= '0; tmr <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q   <= 1'b1;
          hi_q     <= 1'b0;
          have_ref <= 1'b0;
          recheck  <= 1'b0;
          fail_lo  <= 1'b0;
          tmr      <= '0;
          mode_q   <= toggle_mode;
          exp_q    <= expect_data;
          addr_q   <= verify_addr;
          err_q    <= 2'd0;
        end
      end else begin
        if (!expired) tmr <= tmr + 1'b1;
        if (hit) begin
          have_ref <= 1'b1;
          ref_bit  <= tg_bit;
          if (escalate) recheck <= 1'b1;
          if (settle) begin
            if (!hi_q) begin
              fail_lo  <= lane_bad;
              hi_q     <= 1'b1;
              have_ref <= 1'b0;
              recheck  <= 1'b0;
              tmr      <= '0;
            end else begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
              err_q  <= {lane_bad, fail_lo};
            end
          end
        end
      end
    end
  end

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r8_done_idle:   assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r2_start_taken: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  a_r2_addr_hold:   assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(rd_addr));
  a_r6_timer_cap:   assert property (@(posedge clk) disable iff (!rst_n) tmr <= TW'(TIMEOUT));
  a_r5_fail_rechk:  assert property (@(posedge clk) disable iff (!rst_n) $rose(fail_lo) |-> $past(recheck));
  a_r7_lane_order:  assert property (@(posedge clk) disable iff (!rst_n) $rose(hi_q) |-> !have_ref && !recheck);

endmodule

// File: tb/tb_flash_done_poller.sv
module tb_flash_done_poller;
  localparam int AW = 21;
  localparam int TMO = 20;

  logic clk = 0, rst_n = 0, start = 0, toggle_mode = 0, rd_ack = 0;
  logic [AW-1:0] verify_addr = '0;
  logic [15:0] expect_data = '0, rd_data = '0;
  logic rd_req, busy, done;
  logic [AW-1:0] rd_addr;
  logic [1:0] err_code;

  flash_done_poller #(.AW(AW), .TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .toggle_mode(toggle_mode),
    .verify_addr(verify_addr), .expect_data(expect_data), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data), .busy(busy),
    .done(done), .err_code(err_code));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] words[$];

  // reference model state
  int m_busy = 0, m_lane = 0, m_have = 0, m_ref = 0, m_rech = 0, m_tmr = 0;
  int m_flo = 0, m_done = 0, m_err = 0, m_mode = 0;
  logic [15:0] m_exp = '0;
  logic [AW-1:0] m_addr = '0;

  always @(posedge clk) begin
    int st, tg, lim, eb, comp, judged;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_err = 0; m_addr = '0;
    end else begin
      m_done = 0;
      if (m_busy == 0) begin
        if (start) begin
          m_busy = 1; m_lane = 0; m_have = 0; m_rech = 0; m_tmr = 0; m_flo = 0;
          m_mode = toggle_mode; m_exp = expect_data; m_addr = verify_addr; m_err = 0;
        end
      end else begin
        // timer value seen by this edge's judgement is the pre-increment one
        int t_now;
        t_now = m_tmr;
        if (m_tmr < TMO) m_tmr++;
        if (rd_ack) begin
          st  = m_lane ? rd_data[15] : rd_data[7];
          tg  = m_lane ? rd_data[14] : rd_data[6];
          lim = m_lane ? rd_data[13] : rd_data[5];
          eb  = m_lane ? m_exp[15]   : m_exp[7];
          judged = (m_mode == 0) || m_have;
          comp = m_mode ? (m_have && tg == m_ref) : (st == eb);
          if (judged && (comp || m_rech)) begin
            if (m_lane == 0) begin
              m_flo = !comp; m_lane = 1; m_have = 0; m_rech = 0; m_tmr = 0;
            end else begin
              m_busy = 0; m_done = 1; m_err = m_flo + (comp ? 0 : 2);
            end
          end else begin
            if (judged && (lim || t_now >= TMO)) m_rech = 1;
            m_have = 1; m_ref = tg;
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // read responder and per-cycle comparison
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R2 rd_req", rd_req, m_busy);
      if (m_busy != 0) chk("R2 rd_addr", rd_addr, m_addr);
      chk("R7 busy", busy, m_busy);
      chk("R8 done", done, m_done);
      chk("R8 err_code", err_code, m_err);
    end
    if (rd_req && (cyc % 3 != 1)) begin
      rd_ack <= 1;
      rd_data <= (words.size() > 0) ? words.pop_front() : 16'h0000;
    end else begin
      rd_ack <= 0;
    end
  end

  task automatic run(input bit tm, input logic [15:0] ex, input logic [AW-1:0] a,
                     input int exp_err, input string tag, input bit poke);
    int n;
    @(negedge clk);
    toggle_mode = tm; expect_data = ex; verify_addr = a; start = 1;
    @(negedge clk);
    start = 0;
    n = 0;
    while (!done && n < 500) begin
      if (poke && n == 3) begin
        toggle_mode = ~tm; expect_data = ~ex; verify_addr = ~a; start = 1;
      end else start = 0;
      @(negedge clk);
      n++;
    end
    start = 0;
    chk({tag, " done seen"}, done, 1);
    chk({tag, " code"}, err_code, exp_err);
    @(negedge clk);
    chk({tag, " code held"}, err_code, exp_err);
    chk({tag, " idle"}, busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);
    chk("R1 rd_req", rd_req, 0); chk("R1 err", err_code, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after release", busy, 0);

    // R3 erase poll: status bit 0 while busy, 1 when done; both lanes pass
    words = '{16'h0000, 16'h00FF, 16'h00FF, 16'hFF00};
    run(0, 16'hFFFF, 21'h12345, 0, "R3 erase", 0);

    // R5 low lane flag then still incomplete -> fail; high passes
    words = '{16'h0020, 16'h0020, 16'h0000};
    run(0, 16'h0080, 21'h00400, 1, "R5 low fail", 0);

    // R5 both fail; R2 start mid-poll ignored
    words = '{16'h00A0, 16'h00A0, 16'hA000, 16'hA000};
    run(0, 16'h0000, 21'h1F000, 3, "R5 both fail R2", 1);

    // R5 re-read completes: flag seen, then lane passes
    words = '{16'h00A0, 16'h0000, 16'h2000, 16'h0000};
    run(0, 16'h0000, 21'h00001, 0, "R5 recheck pass", 0);

    // R4 R6 R7 toggle: low stops toggling, high toggles until timer expires
    words = '{16'h0000, 16'h0040, 16'h0040};
    for (int i = 0; i < 40; i++) words.push_back((i % 2) ? 16'h4000 : 16'h0000);
    run(1, 16'h0000, 21'h0ABCD, 2, "R4 R6 R7 toggle timeout", 0);

    // R4 toggle both lanes settle quickly
    words = '{16'h0040, 16'h0040, 16'h4000, 16'h0000, 16'h0000};
    run(1, 16'h1234, 21'h00777, 0, "R4 toggle pass", 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule